// File: doc/BRIEF.md
# Wildcard Addressable Frame Register

This block holds the rows of one configuration frame while the frame is being assembled, then streams the finished frame out to configuration memory. Each row is 18 bits wide. The rows run from a top I/O row, through one row per logic row, to a bottom I/O row. A write presents a row address, a don't-care mask and an 18-bit value. In a single cycle the write updates every row whose index agrees with the address on all unmasked bits, so one write can fill a whole group of rows that share a value.

The stored rows are never cleared between frames. A frame that differs only slightly from the last one is therefore built by writing just the rows that changed. A one-cycle commit pulse then sends the whole frame as 32-bit words under a valid/ready handshake. The top row goes first. Zero pad bits fill the last word out to the 32-bit boundary. While a frame is being sent, writes are stalled so that the frame cannot change part way through.

Top module: `wc_frame_reg`

## Requirements
- R1: Row index 0 is the top I/O row, indices 1 to LOGIC_ROWS are the logic rows, and index LOGIC_ROWS+1 is the bottom I/O row. The frame is sent row 0 first. Row 0 fills bits 31:14 of the first word, and every later row follows directly below the previous one with no gap.
- R2: A frame is ceil((LOGIC_ROWS+2)*18/32) words long. Every bit after the last row, at the low end of the final word, is 0.
- R3: A wr_mask bit of 1 makes that address bit a don't-care. An accepted write stores wr_data in every existing row whose index equals wr_addr on all bits where wr_mask is 0, and all of these rows change in the same cycle.
- R4: With wr_mask all zero, an accepted write changes exactly the one row at wr_addr and no other row.
- R5: A row that is not written keeps its value across any number of writes to other rows and across any number of commits.
- R6: A write whose matched indices lie at or above LOGIC_ROWS+2 has no effect on those indices. When no existing row matches, no row changes.
- R7: After reset every row holds 0, wr_ready is 1 and out_valid is 0.
- R8: A commit seen while idle raises out_valid on the next cycle. A word is consumed on each cycle where out_valid and out_ready are both 1. While out_ready is 0, out_data stays unchanged. out_last is 1 only on the final word, and out_valid drops on the cycle after that word is taken.
- R9: While a frame is being sent, wr_ready is 0, any write offered is not applied, and a commit pulse is ignored.
- R10: A write and a commit in the same idle cycle are both accepted, and the frame that is sent includes that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Row write request |
| wr_ready | output | 1 | High when a write can be accepted (idle) |
| wr_addr | input | ADDR_W | Row index of the write |
| wr_mask | input | ADDR_W | Don't-care bits of wr_addr, 1 = ignore |
| wr_data | input | 18 | Value written to every matched row |
| commit | input | 1 | Pulse that starts sending the frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the output word |
| out_data | output | 32 | Frame word, top row first |
| out_last | output | 1 | Marks the final word of the frame |

## Verification
The bench uses a small build with three logic rows, so there are five rows and a 3-bit address. Indices 5 to 7 name no row. Every address is tried with every mask. The all-zero masks separate a single-row write from a write to a nonexistent row. The partial masks show that matched rows are found by comparing bits, not by a range. The all-ones mask shows that a broadcast fills every row in one cycle. After each write the full frame is streamed and compared word by word with a model built from arithmetic, so row order, packing, zero padding and persistence are all checked on every pass. Separate runs hold out_ready low, offer writes and commits while a frame is being sent, and combine a write with a commit in the same cycle.

// File: rtl/wc_frame_pkg.sv
package wc_frame_pkg;
    localparam int ROW_W  = 18;
    localparam int WORD_W = 32;

    function automatic int words_for(input int bits);
        return (bits + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/wc_row_bank.sv
module wc_row_bank
    import wc_frame_pkg::*;
#(
    parameter int NROWS  = 66,
    parameter int ADDR_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [ADDR_W-1:0]        wr_mask,
    input  logic [ROW_W-1:0]         wr_data,
    output logic [NROWS*ROW_W-1:0]   rows_o
);
    typedef struct packed {
        logic [NROWS-1:0][ROW_W-1:0] rows;
    } bank_t;

    bank_t             st_d, st_q;
    logic [NROWS-1:0]  hit;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        localparam logic [ADDR_W-1:0] ROW_IDX = ADDR_W'(r);
        assign hit[r] = wr_en && (((ROW_IDX ^ wr_addr) & ~wr_mask) == '0);
        assign rows_o[(NROWS-r)*ROW_W-1 -: ROW_W] = st_q.rows[r];

        // R4: an exact write reaches its row and leaves every other row alone
        a_r4_exact_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_mask == '0 && wr_addr == ROW_IDX) |=> st_q.rows[r] == $past(wr_data));
        a_r4_exact_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_mask == '0 && wr_addr != ROW_IDX) |=> $stable(st_q.rows[r]));
    end

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NROWS; r++) begin
            if (hit[r]) st_d.rows[r] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: an exact write to an index with no row changes nothing
    a_r6_no_row: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0 && int'(wr_addr) >= NROWS) |=> $stable(st_q));
endmodule

// File: rtl/wc_frame_ser.sv
module wc_frame_ser
    import wc_frame_pkg::*;
#(
    parameter int NWORDS = 38
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [NWORDS*WORD_W-1:0] frame_i,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_last,
    output logic                     busy_o
);
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int FBITS = NWORDS * WORD_W;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } ser_t;

    ser_t                           st_d, st_q;
    logic [NWORDS-1:0][WORD_W-1:0]  words;

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        assign words[k] = frame_i[FBITS-1-k*WORD_W -: WORD_W];
    end

    assign out_valid = st_q.busy;
    assign out_data  = words[st_q.idx];
    assign out_last  = st_q.busy && (st_q.idx == IDX_W'(NWORDS-1));
    assign busy_o    = st_q.busy;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (commit) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
            end
        end else if (out_ready) begin
            if (out_last) st_d.busy = 1'b0;
            else          st_d.idx  = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a stalled word is held
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8: the frame ends after its final word is taken
    a_r8_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
    // R8: an idle commit starts the stream on the next cycle
    a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && commit) |=> (out_valid && !$past(out_valid)));
endmodule

// File: rtl/wc_frame_reg.sv
module wc_frame_reg
    import wc_frame_pkg::*;
#(
    parameter int LOGIC_ROWS = 64,
    localparam int NROWS      = LOGIC_ROWS + 2,
    localparam int ADDR_W     = $clog2(NROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_mask,
    input  logic [17:0]       wr_data,
    input  logic              commit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_last
);
    localparam int ROW_BITS   = NROWS * ROW_W;
    localparam int NWORDS     = words_for(ROW_BITS);
    localparam int FRAME_BITS = NWORDS * WORD_W;
    localparam int PAD        = FRAME_BITS - ROW_BITS;

    logic                   busy;
    logic                   wr_en;
    logic [ROW_BITS-1:0]    rows_flat;
    logic [FRAME_BITS-1:0]  frame_flat;

    assign wr_ready = !busy;
    assign wr_en    = wr_valid && wr_ready;

    wc_row_bank #(.NROWS(NROWS), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rows_o  (rows_flat)
    );

    if (PAD > 0) begin : g_pad
        assign frame_flat = {rows_flat, {PAD{1'b0}}};
        // R2: tail of the last word is zero
        a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            out_last |-> out_data[PAD-1:0] == '0);
    end else begin : g_nopad
        assign frame_flat = rows_flat;
    end

    wc_frame_ser #(.NWORDS(NWORDS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .frame_i   (frame_flat),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .busy_o    (busy)
    );

    // R9: the frame content cannot change while it is being sent
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(rows_flat));
endmodule

// File: tb/wc_frame_reg_test.sv
`timescale 1ns/1ps
module wc_frame_reg_test;
    localparam int LR = 3;
    localparam int NR = LR + 2;
    localparam int NW = 3;
    localparam int FB = NW * 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [2:0]  wr_addr = '0;
    logic [2:0]  wr_mask = '0;
    logic [17:0] wr_data = '0;
    logic        commit = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [17:0] model [NR];

    always #2.5 clk = ~clk;

    wc_frame_reg #(.LOGIC_ROWS(LR)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data), .commit(commit),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [FB-1:0] exp_frame();
        logic [FB-1:0] f = '0;
        for (int i = 0; i < NR; i++) f[FB-1-18*i -: 18] = model[i];
        return f;
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [2:0] m, input logic [17:0] d);
        for (int r = 0; r < NR; r++)
            if (((3'(r) ^ a) & ~m) == 3'b000) model[r] = d;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [2:0] m, input logic [17:0] d);
        @(negedge clk);
        check(wr_ready == 1'b1, "R9 idle wr_ready", 32'(wr_ready), 32'd1);
        wr_valid = 1'b1; wr_addr = a; wr_mask = m; wr_data = d;
        @(posedge clk);
        #1 wr_valid = 1'b0;
        model_write(a, m, d);
    endtask

    // drain a frame whose commit was taken at the last posedge
    task automatic drain(input string tag, input int stall);
        logic [FB-1:0] f = exp_frame();
        for (int w = 0; w < NW; w++) begin
            @(negedge clk);
            check(out_valid == 1'b1, {tag, " R8 valid"}, 32'(out_valid), 32'd1);
            check(out_data == f[FB-1-32*w -: 32], {tag, " R1 R2 word"}, out_data, f[FB-1-32*w -: 32]);
            check(out_last == (w == NW-1), {tag, " R8 last"}, 32'(out_last), 32'(w == NW-1));
            if (w == stall) begin
                out_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
                check(out_data == f[FB-1-32*w -: 32], {tag, " R8 hold"}, out_data, f[FB-1-32*w -: 32]);
            end
            out_ready = 1'b1;
            @(posedge clk);
            #1 out_ready = 1'b0;
        end
        @(negedge clk);
        check(out_valid == 1'b0, {tag, " R8 end"}, 32'(out_valid), 32'd0);
        check(wr_ready == 1'b1, {tag, " R9 ready after"}, 32'(wr_ready), 32'd1);
    endtask

    task automatic frame_check(input string tag, input int stall);
        @(negedge clk);
        commit = 1'b1;
        @(posedge clk);
        #1 commit = 1'b0;
        drain(tag, stall);
    endtask

    initial begin
        for (int i = 0; i < NR; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(wr_ready == 1'b1, "R7 wr_ready", 32'(wr_ready), 32'd1);
        check(out_valid == 1'b0, "R7 out_valid", 32'(out_valid), 32'd0);
        frame_check("R7 zero frame", -1);

        // every address with every mask (R3, R4, R5, R6)
        for (int a = 0; a < 8; a++) begin
            for (int m = 0; m < 8; m++) begin
                logic [17:0] d = 18'((a * 8 + m) * 18'h0B3D ^ 18'h2A5A1);
                string tag;
                if (m == 0 && a >= NR)      tag = "R6 no row";
                else if (m == 0)            tag = "R4 one row";
                else                        tag = "R3 wildcard R5 keep";
                do_write(3'(a), 3'(m), d);
                frame_check(tag, (a + m) % 4);
            end
        end

        // R5: several commits without writes leave the rows unchanged
        frame_check("R5 repeat commit", -1);
        frame_check("R5 repeat commit", 1);

        // R9: write and commit offered while the frame is sent
        @(negedge clk);
        commit = 1'b1;
        @(posedge clk);
        #1 commit = 1'b0;
        wr_valid = 1'b1; wr_addr = 3'd0; wr_mask = 3'b111; wr_data = 18'h3FFFF;
        commit = 1'b1;
        @(negedge clk);
        check(wr_ready == 1'b0, "R9 busy wr_ready", 32'(wr_ready), 32'd0);
        @(posedge clk);
        #1 wr_valid = 1'b0; commit = 1'b0;
        drain("R9 held off", -1);
        frame_check("R9 write not applied", -1);

        // R10: write and commit in the same idle cycle
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 3'd2; wr_mask = 3'b000; wr_data = 18'h1C3C3;
        commit = 1'b1;
        @(posedge clk);
        #1 wr_valid = 1'b0; commit = 1'b0;
        model_write(3'd2, 3'b000, 18'h1C3C3);
        drain("R10 same cycle", 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule